// File: doc/BRIEF.md
# Eight-Operation Arithmetic Logic Unit with Sectioned Carry-Select Adder

This block is a purely combinational arithmetic logic unit for a wide datapath. It takes two operands of a parameterised width and a 3-bit operation code. It returns a result word of the same width and a single carry flag. There is no clock and no state, so the outputs follow the inputs through logic alone.

Add and subtract share one adder. Subtract is formed by complementing the second operand and forcing the carry-in high. The adder splits the word into sections whose sizes grow by one bit per section. The lowest section ripples from the real carry-in. Every higher section ripples from a zero carry and also forms an incremented copy of its own partial sum through a chain of AND gates. The carry arriving from below then selects between the two copies.

The remaining six codes give the bitwise operations and the one-position shifts of the first operand. The default width is 128 bits.

Top module: `sel_alu`

## Requirements
- R1: Code 3'b000 gives result = opA + opB modulo 2^WIDTH, with carryOut equal to the carry out of the top bit.
- R2: Code 3'b001 gives result = opA - opB modulo 2^WIDTH, computed as opA + ~opB + 1. carryOut is 1 exactly when opA >= opB (unsigned), meaning no borrow.
- R3: Code 3'b010 gives result = opA | opB.
- R4: Code 3'b011 gives result = opA & opB.
- R5: Code 3'b100 gives result = opA ^ opB.
- R6: Code 3'b101 gives result = opA shifted right by one bit, with a zero entering the top bit.
- R7: Code 3'b110 gives result = opA shifted left by one bit, with a zero entering bit 0.
- R8: Code 3'b111 gives result = ~opA.
- R9: For every code from 3'b010 to 3'b111, carryOut is 0.
- R10: A carry produced in the lowest bit reaches every section of the adder. For example, all-ones plus one gives result 0 and carryOut 1, and a carry born in one section is passed across a following section whose bits all propagate.
- R11: For codes 3'b101, 3'b110 and 3'b111, opB has no effect on result or carryOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand; also the only source for shifts and NOT |
| opB | input | WIDTH | Second operand |
| opSel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| carryOut | output | 1 | Adder carry for add and subtract; 0 otherwise |

## Verification
The block holds no state. A fault in a section's zero-carry ripple, its increment chain or its select therefore shows up on result and carryOut for the very vector that exercises it. It does not wait for later cycles. Section faults show only when a carry actually crosses the boundary of the broken section. For that reason the vectors include all-propagate operands and carries born just below section edges, alongside random operands. A swapped decode shows immediately as the wrong operation on every vector that uses that code.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_OR  = 3'b010,
    OP_AND = 3'b011,
    OP_XOR = 3'b100,
    OP_SHR = 3'b101,
    OP_SHL = 3'b110,
    OP_NOT = 3'b111
  } opCodeT;

  typedef enum logic [2:0] {
    PICK_SUM,
    PICK_OR,
    PICK_AND,
    PICK_XOR,
    PICK_SHR,
    PICK_SHL,
    PICK_NOT
  } pickT;

  // Strobes from decode to datapath
  typedef struct packed {
    logic arith;    // adder result drives the outputs
    logic invertB;  // complement second operand
    logic carryIn;  // adder carry-in
    pickT pick;     // result source
  } ctrlT;

  // Nominal section size: 2, 2, 3, 4, 5, ...
  function automatic int secNominal(input int k);
    return (k == 0) ? 2 : k + 1;
  endfunction

  function automatic int secStart(input int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += secNominal(j);
    return s;
  endfunction

  function automatic int secWidth(input int k, input int total);
    int rem;
    rem = total - secStart(k);
    return (secNominal(k) < rem) ? secNominal(k) : rem;
  endfunction

  function automatic int secCount(input int total);
    int k;
    k = 0;
    while (secStart(k) < total) k++;
    return k;
  endfunction

endpackage

// File: rtl/csla_section.sv
module csla_section #(
  parameter int W     = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  if (FIRST) begin : g_plain
    // Lowest section ripples from the true carry-in
    logic [W:0] rc;
    always_comb begin
      rc[0] = cin;
      for (int i = 0; i < W; i++) begin
        sum[i]   = a[i] ^ b[i] ^ rc[i];
        rc[i+1]  = (a[i] & b[i]) | (rc[i] & (a[i] ^ b[i]));
      end
      cout = rc[W];
    end
  end else begin : g_select
    logic [W-1:0] sumZero;
    logic [W-1:0] sumOne;
    logic         carryZero;
    logic         carryOne;
    logic [W:0]   rc;
    logic [W:0]   allOnes;

    // Zero-carry ripple
    always_comb begin
      rc[0] = 1'b0;
      for (int i = 0; i < W; i++) begin
        sumZero[i] = a[i] ^ b[i] ^ rc[i];
        rc[i+1]    = (a[i] & b[i]) | (rc[i] & (a[i] ^ b[i]));
      end
      carryZero = rc[W];
    end

    // Increment by AND chain instead of a second ripple
    always_comb begin
      allOnes[0] = 1'b1;
      for (int i = 0; i < W; i++) begin
        sumOne[i]    = sumZero[i] ^ allOnes[i];
        allOnes[i+1] = allOnes[i] & sumZero[i];
      end
      carryOne = carryZero | allOnes[W];
    end

    assign sum  = cin ? sumOne : sumZero;
    assign cout = cin ? carryOne : carryZero;
  end

endmodule

// File: rtl/csla_adder.sv
module csla_adder
  import sel_alu_pkg::*;
#(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NSEC = secCount(WIDTH);

  logic [NSEC:0] chain;
  assign chain[0] = cin;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    localparam int LO = secStart(k);
    localparam int WD = secWidth(k, WIDTH);
    csla_section #(
      .W     (WD),
      .FIRST (k == 0)
    ) u_sec (
      .a    (a[LO +: WD]),
      .b    (b[LO +: WD]),
      .cin  (chain[k]),
      .sum  (sum[LO +: WD]),
      .cout (chain[k+1])
    );
  end

  assign cout = chain[NSEC];

  // Section stitching must equal the true sum (R10)
  always_comb begin
    a_r10_section_chain: assert ({cout, sum} ==
                                 ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("sectioned sum mismatch");
  end

endmodule

// File: rtl/sel_alu_ctrl.sv
module sel_alu_ctrl
  import sel_alu_pkg::*;
(
  input  logic [2:0] opSel,
  output ctrlT       ctrl
);

  always_comb begin
    ctrl = '{arith: 1'b0, invertB: 1'b0, carryIn: 1'b0, pick: PICK_SUM};
    unique case (opCodeT'(opSel))
      OP_ADD: ctrl.arith = 1'b1;
      OP_SUB: begin
        ctrl.arith   = 1'b1;
        ctrl.invertB = 1'b1;
        ctrl.carryIn = 1'b1;
      end
      OP_OR:  ctrl.pick = PICK_OR;
      OP_AND: ctrl.pick = PICK_AND;
      OP_XOR: ctrl.pick = PICK_XOR;
      OP_SHR: ctrl.pick = PICK_SHR;
      OP_SHL: ctrl.pick = PICK_SHL;
      OP_NOT: ctrl.pick = PICK_NOT;
      default: ctrl.pick = PICK_SUM;
    endcase
  end

  // Subtract strobes travel together; adder output only for arithmetic (R2)
  always_comb begin
    a_r2_sub_strobes: assert (ctrl.invertB == ctrl.carryIn &&
                              (!ctrl.invertB || ctrl.arith))
      else $error("subtract strobes inconsistent");
  end

endmodule

// File: rtl/sel_alu_datapath.sv
module sel_alu_datapath
  import sel_alu_pkg::*;
#(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrlT             ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  logic [WIDTH-1:0] addendB;
  logic [WIDTH-1:0] adderSum;
  logic             adderCarry;

  assign addendB = ctrl.invertB ? ~opB : opB;

  csla_adder #(.WIDTH(WIDTH)) u_adder (
    .a    (opA),
    .b    (addendB),
    .cin  (ctrl.carryIn),
    .sum  (adderSum),
    .cout (adderCarry)
  );

  always_comb begin
    unique case (ctrl.pick)
      PICK_SUM: result = adderSum;
      PICK_OR:  result = opA | opB;
      PICK_AND: result = opA & opB;
      PICK_XOR: result = opA ^ opB;
      PICK_SHR: result = {1'b0, opA[WIDTH-1:1]};
      PICK_SHL: result = {opA[WIDTH-2:0], 1'b0};
      PICK_NOT: result = ~opA;
      default:  result = adderSum;
    endcase
  end

  assign carryOut = ctrl.arith & adderCarry;

  always_comb begin
    if (ctrl.arith && !ctrl.invertB) begin
      a_r1_add_word: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB}))
        else $error("add result wrong");
    end
    if (ctrl.arith && ctrl.invertB) begin
      a_r2_no_borrow: assert (carryOut == (opA >= opB) && result == opA - opB)
        else $error("subtract result wrong");
    end
    if (!ctrl.arith) begin
      a_r9_carry_quiet: assert (!carryOut)
        else $error("carry raised on non-arithmetic op");
    end
    if (ctrl.pick == PICK_SHR) begin
      a_r6_top_zero: assert (!result[WIDTH-1])
        else $error("right shift top bit not zero");
    end
    if (ctrl.pick == PICK_SHL) begin
      a_r7_low_zero: assert (!result[0])
        else $error("left shift low bit not zero");
    end
  end

endmodule

// File: rtl/sel_alu.sv
module sel_alu
  import sel_alu_pkg::*;
#(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  ctrlT ctrl;

  sel_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  sel_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: tb/sel_alu_test.sv
`timescale 1ns/1ps
module sel_alu_test;

  localparam int W = 128;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   opSel = 3'b000;
  logic [W-1:0] result;
  logic         carryOut;

  sel_alu #(.WIDTH(W)) uut (
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .result   (result),
    .carryOut (carryOut)
  );

  logic [W-1:0] expRes[$];
  logic         expCry[$];
  string        expTag[$];
  int           applied = 0;
  int           miscompares = 0;
  bit           finished = 1'b0;

  function automatic logic [W:0] model(input logic [2:0] op,
                                       input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    case (op)
      3'b000: return {1'b0, a} + {1'b0, b};
      3'b001: return {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
      3'b010: return {1'b0, a | b};
      3'b011: return {1'b0, a & b};
      3'b100: return {1'b0, a ^ b};
      3'b101: return {1'b0, a >> 1};
      3'b110: return {1'b0, a << 1};
      default: return {1'b0, ~a};
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Driver: apply at posedge, queue expectation
  task automatic drive(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string tag);
    logic [W:0] e;
    @(posedge clk);
    opSel = op;
    opA   = a;
    opB   = b;
    e = model(op, a, b);
    expRes.push_back(e[W-1:0]);
    expCry.push_back(e[W]);
    expTag.push_back(tag);
  endtask

  // Monitor: compare at negedge
  always @(negedge clk) begin
    if (expRes.size() > 0) begin
      logic [W-1:0] r;
      logic         c;
      string        t;
      r = expRes.pop_front();
      c = expCry.pop_front();
      t = expTag.pop_front();
      applied++;
      if (result !== r || carryOut !== c) begin
        miscompares++;
        $display("FAIL %s: got result=%h carry=%b expected result=%h carry=%b",
                 t, result, carryOut, r, c);
      end
    end
  end

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  initial begin
    logic [W-1:0] a;
    logic [W-1:0] b;
    // Idle state: all-zero inputs give zero add
    drive(3'b000, '0, '0, "R1 idle");
    // R1 add
    drive(3'b000, 128'd5, 128'd7, "R1 small");
    drive(3'b000, ONES, ONES, "R1 both max");
    // R10 carry crosses every section
    drive(3'b000, ONES, ONE, "R10 full ripple");
    drive(3'b000, ONES >> 1, ONE, "R10 into top bit");
    for (int s = 2; s < W; s += 7)
      drive(3'b000, (ONE << s) - ONE, ONE, "R10 section edge");
    drive(3'b000, {{(W-8){1'b0}}, 8'hF0}, {{(W-8){1'b0}}, 8'h10}, "R10 mid carry");
    // R2 subtract and borrow
    drive(3'b001, 128'd9, 128'd4, "R2 no borrow");
    drive(3'b001, 128'd4, 128'd9, "R2 borrow");
    drive(3'b001, 128'd33, 128'd33, "R2 equal");
    drive(3'b001, '0, ONE, "R2 zero minus one");
    // R3..R8 and R9 carry quiet
    drive(3'b010, ONES, '0, "R3 or R9");
    drive(3'b011, ONES, ONES, "R4 and R9");
    drive(3'b100, ONES, ONES >> 4, "R5 xor R9");
    drive(3'b101, ONES, '0, "R6 shr fill R9");
    drive(3'b110, ONES, '0, "R7 shl fill R9");
    drive(3'b111, '0, ONES, "R8 not R9");
    // R11 opB ignored for shift and NOT
    a = rnd();
    for (int op = 5; op < 8; op++) begin
      drive(3'(op), a, '0, "R11 b zero");
      drive(3'(op), a, ONES, "R11 b ones");
      drive(3'(op), a, rnd(), "R11 b random");
    end
    // Random sweep across all codes
    for (int i = 0; i < 400; i++) begin
      a = rnd();
      b = rnd();
      drive(3'(i % 8), a, b, reqOf(3'(i % 8)));
    end
    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule